// File: doc/BRIEF.md
# Speculative Register Checkpoint and Gated Store Unit

This block keeps the speculative architectural state of one translated code region. Each guest-state register has a working copy, which execution writes, and a shadow copy, which holds the last checkpoint. Stores from execution do not go to memory directly. They wait in a gated queue until the region is confirmed.

A one-cycle commit pulse copies every working register into its shadow and releases all queued stores. The released stores then drain to memory in program order over a valid/ready write port. A one-cycle rollback pulse copies every shadow back into its working register and drops every store that was not released. Which of the 64 registers have shadows is set by a mask parameter. Registers outside the mask are plain registers and keep their values across a rollback.

The drain side is a two-state machine. In state `DRN_HOLD` no released store is waiting and `mem_valid` is low. In state `DRN_RELEASE` at least one released store is waiting, the oldest is shown on the memory port, and each accepted handshake retires it. The transition HOLD→RELEASE is taken on a commit that covers at least one queued store. The transition RELEASE→HOLD is taken when the last released store is accepted and no commit releases further stores in that cycle.

Top module: `spec_ckpt_unit`

## Requirements
- R1: After reset every working and shadow copy reads zero, `mem_valid` is 0 and `st_full` is 0.
- R2: A register write changes only the working copy. `rd_data` shows the working copy of `rd_idx` from the cycle after the write, and `dbg_data` (the shadow) does not change until a commit.
- R3: A commit copies every shadowed working register into its shadow in one cycle. A write in the same cycle is included in the checkpoint.
- R4: A rollback restores every shadowed working register from its shadow in one cycle. A register write in the same cycle is discarded.
- R5: A register whose bit in `SHADOW_MASK` is 0 keeps its working value across a rollback, and its `dbg_data` reads zero.
- R6: A store reaches the memory port only after a commit that covers it. A store enqueued in the same cycle as a commit is covered by that commit.
- R7: A rollback drops every store not yet released, including one enqueued in the rollback cycle. Stores already released keep draining.
- R8: Released stores leave in enqueue order, one per cycle with `mem_valid && mem_ready`. `mem_addr` and `mem_data` hold steady while `mem_ready` is low.
- R9: `st_full` is 1 exactly when `QDEPTH` stores are held. An enqueue while `st_full` is 1 is refused and never reaches memory.
- R10: When commit and rollback arrive in the same cycle, the rollback takes effect and the commit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 6 | Register write index |
| wr_data | input | DW | Register write data |
| rd_idx | input | 6 | Register read index |
| rd_data | output | DW | Working copy of `rd_idx` |
| dbg_idx | input | 6 | Shadow debug read index |
| dbg_data | output | DW | Shadow copy of `dbg_idx` (zero if not shadowed) |
| st_en | input | 1 | Store enqueue request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_full | output | 1 | Store queue full, enqueue refused |
| commit | input | 1 | Checkpoint pulse |
| rollback | input | 1 | Restore pulse |
| mem_valid | output | 1 | Released store present on memory port |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | AW | Store address to memory |
| mem_data | output | DW | Store data to memory |

## Verification
The bench drives a write, a store enqueue or a commit into the same cycle as a commit or a rollback. A design that got this wrong would leave a stale shadow, keep a write that should have been discarded, or send a store that should have been dropped. It stalls `mem_ready` while released stores are waiting. An unstable port here would corrupt or duplicate a memory write. It fills the queue and pushes one more store. A design that accepted it would overwrite the oldest entry. It also rolls back a register outside the mask, which a design that restored every register would wrongly reset.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int SCR_NREG = 64;
    localparam int SCR_DW   = 32;
    localparam int SCR_AW   = 32;
    localparam int SCR_QDEP = 8;

    typedef enum logic {
        DRN_HOLD    = 1'b0,
        DRN_RELEASE = 1'b1
    } drain_state_e;
endpackage

// File: rtl/scr_regfile.sv
module scr_regfile #(
    parameter int              NREG        = 64,
    parameter int              DW          = 32,
    parameter logic [NREG-1:0] SHADOW_MASK = '1,
    localparam int             IW          = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic          rollback,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic [IW-1:0] dbg_idx,
    output logic [DW-1:0] dbg_data
);
    logic [NREG-1:0][DW-1:0] work_all;
    logic [NREG-1:0][DW-1:0] shad_all;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic          hit;
        logic [DW-1:0] work_q;
        assign hit         = wr_en && (wr_idx == IW'(i));
        assign work_all[i] = work_q;

        if (SHADOW_MASK[i]) begin : g_shadowed
            logic [DW-1:0] shad_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    work_q <= '0;
                    shad_q <= '0;
                end else if (rollback) begin
                    work_q <= shad_q;
                end else begin
                    if (hit)    work_q <= wr_data;
                    if (commit) shad_q <= hit ? wr_data : work_q;
                end
            end
            assign shad_all[i] = shad_q;
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)                work_q <= '0;
                else if (!rollback && hit) work_q <= wr_data;
            end
            assign shad_all[i] = '0;
        end
    end

    assign rd_data  = work_all[rd_idx];
    assign dbg_data = shad_all[dbg_idx];
endmodule

// File: rtl/scr_store_gate.sv
module scr_store_gate
    import scr_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int AW     = 32,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_en,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_full,
    input  logic          commit,
    input  logic          rollback,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CW = $clog2(QDEPTH + 1);

    logic [AW-1:0] slot_addr [QDEPTH];
    logic [DW-1:0] slot_data [QDEPTH];
    logic [PW-1:0] head_q, tail;
    logic [CW-1:0] cnt_q, rel_q, cnt_n, rel_n, cnt_pop, rel_pop;
    logic          push, pop;
    drain_state_e  state_q, state_n;

    assign st_full = (cnt_q == CW'(QDEPTH));
    assign push    = st_en && !st_full && !rollback;
    assign pop     = mem_valid && mem_ready;
    assign tail    = head_q + PW'(cnt_q);
    assign cnt_pop = cnt_q - CW'(pop);
    assign rel_pop = rel_q - CW'(pop);

    always_comb begin
        if (rollback) begin
            cnt_n = rel_pop;
            rel_n = rel_pop;
        end else begin
            cnt_n = cnt_pop + CW'(push);
            rel_n = commit ? cnt_n : rel_pop;
        end
        state_n = (rel_n != '0) ? DRN_RELEASE : DRN_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DRN_HOLD;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            DRN_HOLD:    mem_valid = 1'b0;
            DRN_RELEASE: mem_valid = 1'b1;
            default:     mem_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
            rel_q  <= '0;
        end else begin
            if (pop) head_q <= (head_q == PW'(QDEPTH - 1)) ? '0 : head_q + 1'b1;
            cnt_q <= cnt_n;
            rel_q <= rel_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail] <= st_addr;
            slot_data[tail] <= st_data;
        end
    end

    assign mem_addr = slot_addr[head_q];
    assign mem_data = slot_data[head_q];
endmodule

// File: rtl/spec_ckpt_unit.sv
module spec_ckpt_unit
    import scr_pkg::*;
#(
    parameter int              NREG        = SCR_NREG,
    parameter int              DW          = SCR_DW,
    parameter int              AW          = SCR_AW,
    parameter int              QDEPTH      = SCR_QDEP,
    parameter logic [NREG-1:0] SHADOW_MASK = 64'h0000_0000_FFFF_FFFF,
    localparam int             IW          = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic [IW-1:0] dbg_idx,
    output logic [DW-1:0] dbg_data,
    input  logic          st_en,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_full,
    input  logic          commit,
    input  logic          rollback,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    scr_regfile #(.NREG(NREG), .DW(DW), .SHADOW_MASK(SHADOW_MASK)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .commit(commit), .rollback(rollback),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    scr_store_gate #(.QDEPTH(QDEPTH), .AW(AW), .DW(DW)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .st_en(st_en), .st_addr(st_addr), .st_data(st_data), .st_full(st_full),
        .commit(commit), .rollback(rollback),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
    parameter int              NREG        = 64,
    parameter int              DW          = 32,
    parameter int              AW          = 32,
    parameter logic [NREG-1:0] SHADOW_MASK = '1,
    localparam int             IW          = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [IW-1:0] rd_idx,
    input logic [DW-1:0] rd_data,
    input logic [IW-1:0] dbg_idx,
    input logic [DW-1:0] dbg_data,
    input logic          st_full,
    input logic          commit,
    input logic          rollback,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data
);
    // R2: shadow only moves on a commit
    assert_shadow_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (dbg_idx != $past(dbg_idx)) || (dbg_data == $past(dbg_data)));

    // R3: commit captures the working value
    assert_commit_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rollback && !wr_en && rd_idx == dbg_idx && SHADOW_MASK[dbg_idx])
        |=> (dbg_idx != $past(dbg_idx)) || (dbg_data == $past(rd_data)));

    // R4: rollback restores the shadow into the working copy
    assert_rollback_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && rd_idx == dbg_idx && SHADOW_MASK[dbg_idx])
        |=> (rd_idx != $past(rd_idx)) || (rd_data == $past(dbg_data)));

    // R6: nothing is released without a commit
    assert_gated_until_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !mem_valid) |=> !mem_valid);

    // R7 / R10: rollback never releases stores, even with a commit
    assert_rollback_no_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && !mem_valid) |=> !mem_valid);

    // R8: stalled memory port holds steady
    assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R9: full persists until something leaves
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && !(mem_valid && mem_ready) && !rollback) |=> st_full);
endmodule

bind spec_ckpt_unit scr_checker #(
    .NREG(NREG), .DW(DW), .AW(AW), .SHADOW_MASK(SHADOW_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data),
    .st_full(st_full), .commit(commit), .rollback(rollback),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/spec_ckpt_unit_tb.sv
module spec_ckpt_unit_tb;
    localparam int          Q     = 8;
    localparam logic [63:0] SMASK = 64'h0000_0000_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, st_en = 0, commit = 0, rollback = 0, mem_ready = 0;
    logic [5:0]  wr_idx = 0, rd_idx = 0, dbg_idx = 0;
    logic [31:0] wr_data = 0, st_addr = 0, st_data = 0;
    logic [31:0] rd_data, dbg_data, mem_addr, mem_data;
    logic        st_full, mem_valid;

    always #2.5 clk = ~clk;

    spec_ckpt_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data),
        .st_en(st_en), .st_addr(st_addr), .st_data(st_data), .st_full(st_full),
        .commit(commit), .rollback(rollback),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    string ctx = "reset";

    logic [31:0] m_work [64];
    logic [31:0] m_shad [64];
    logic [31:0] m_qa [Q];
    logic [31:0] m_qd [Q];
    int m_head = 0, m_cnt = 0, m_rel = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_shadow(input int i);
        return SMASK[i] ? m_shad[i] : 32'h0;
    endfunction

    task automatic model_step();
        bit pop, push;
        pop  = (m_rel != 0) && mem_ready;
        push = st_en && (m_cnt != Q) && !rollback;
        if (rollback) begin
            for (int i = 0; i < 64; i++) if (SMASK[i]) m_work[i] = m_shad[i];
        end else begin
            if (wr_en) m_work[wr_idx] = wr_data;
            if (commit) for (int i = 0; i < 64; i++) if (SMASK[i]) m_shad[i] = m_work[i];
        end
        if (pop) begin
            m_head = (m_head + 1) % Q;
            m_cnt--;
            m_rel--;
        end
        if (rollback) m_cnt = m_rel;
        else begin
            if (push) begin
                m_qa[(m_head + m_cnt) % Q] = st_addr;
                m_qd[(m_head + m_cnt) % Q] = st_data;
                m_cnt++;
            end
            if (commit) m_rel = m_cnt;
        end
    endtask

    task automatic cycle();
        #1;
        chk("R2 R4 working read", rd_data, m_work[rd_idx]);
        chk("R3 R5 shadow read", dbg_data, exp_shadow(int'(dbg_idx)));
        chk("R9 full flag", {31'b0, st_full}, {31'b0, m_cnt == Q});
        chk("R6 R7 release", {31'b0, mem_valid}, {31'b0, m_rel != 0});
        if (mem_valid && mem_ready && m_rel != 0) begin
            chk("R8 drain addr", mem_addr, m_qa[m_head]);
            chk("R8 drain data", mem_data, m_qd[m_head]);
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; st_en = 0; commit = 0; rollback = 0;
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        wr_en = 1; wr_idx = 6'(i); wr_data = d;
    endtask

    task automatic st(input logic [31:0] a, input logic [31:0] d);
        st_en = 1; st_addr = a; st_data = d;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        for (int i = 0; i < 64; i++) begin m_work[i] = 0; m_shad[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        ctx = "R1 reset state";
        for (int i = 0; i < 64; i++) begin
            rd_idx = 6'(i); dbg_idx = 6'(i); #1;
            chk("R1 working", rd_data, 32'h0);
            chk("R1 shadow", dbg_data, 32'h0);
        end
        chk("R1 valid", {31'b0, mem_valid}, 32'h0);
        chk("R1 full", {31'b0, st_full}, 32'h0);

        ctx = "R2 write working only";
        rd_idx = 5; dbg_idx = 5;
        wr(5, 32'hA5A5_0001); cycle();
        cycle();
        ctx = "R3 commit with same-cycle write";
        wr(6, 32'h0000_0066); commit = 1; cycle();
        rd_idx = 6; dbg_idx = 6; cycle();
        ctx = "R4 rollback discards same-cycle write";
        wr(5, 32'hBBBB_0002); cycle();
        wr(7, 32'h7777_7777); rollback = 1; rd_idx = 5; dbg_idx = 5; cycle();
        rd_idx = 7; cycle();
        ctx = "R5 unshadowed register survives rollback";
        wr(40, 32'h4040_4040); rd_idx = 40; dbg_idx = 40; cycle();
        rollback = 1; cycle();
        cycle();

        ctx = "R6 stores gated";
        mem_ready = 1;
        st(32'h100, 32'h1); cycle();
        st(32'h104, 32'h2); cycle();
        cycle(); cycle();
        ctx = "R7 rollback drops stores";
        st(32'h108, 32'h3); rollback = 1; cycle();
        cycle(); cycle();
        ctx = "R8 stalled drain";
        mem_ready = 0;
        st(32'h200, 32'hA); cycle();
        st(32'h204, 32'hB); commit = 1; cycle();
        st(32'h208, 32'hC); cycle();
        rollback = 1; cycle();
        cycle(); cycle();
        mem_ready = 1; cycle(); cycle(); cycle();

        ctx = "R9 fill queue";
        mem_ready = 0;
        for (int k = 0; k < Q + 2; k++) begin st(32'h300 + 32'(4 * k), 32'(k)); cycle(); end
        commit = 1; cycle();
        mem_ready = 1;
        for (int k = 0; k < Q + 2; k++) cycle();

        ctx = "R10 commit and rollback together";
        rd_idx = 9; dbg_idx = 9;
        wr(9, 32'h5); commit = 1; cycle();
        wr(9, 32'h9); cycle();
        st(32'h400, 32'h44); commit = 1; rollback = 1; cycle();
        cycle(); cycle();

        ctx = "random";
        r = $urandom(32'd2024);
        for (int n = 0; n < 4000; n++) begin
            rd_idx    = 6'($urandom_range(0, 63));
            dbg_idx   = ($urandom_range(0, 1) == 1) ? rd_idx : 6'($urandom_range(0, 63));
            mem_ready = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 1) == 1) wr($urandom_range(0, 63), $urandom());
            if ($urandom_range(0, 2) == 0) st($urandom(), $urandom());
            if ($urandom_range(0, 11) == 0) commit = 1;
            if ($urandom_range(0, 15) == 0) rollback = 1;
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule